// File: doc/BRIEF.md
# Scan-Loaded Two-Input Registered Lookup Tile

This tile evaluates an arbitrary two-input Boolean function whose truth table lives in four serially loaded configuration flops. While the shift enable is high, configuration bits move one place per clock along the four flops, from the serial input to the serial output. The serial output can feed the next tile, so many tiles form one long configuration chain. While the shift enable is low, the configuration flops keep their contents.

In functional mode, the two select inputs pick one stored bit, and that bit is captured into the current-output register on each rising edge. A second register captures the value the current-output register held before that edge. This one-cycle history lets an external router close simple state loops.

The output registers stay frozen while the configuration is being shifted. Synchronous reset clears the two output registers and leaves the truth table alone.

Top module: `lut2_scan_tile`

## Requirements
- R1: When `rst` is high at a rising edge, `y_now` and `y_prev` are both 0 after that edge.
- R2: With `rst` and `scan_en` low, a rising edge loads `y_now` with table bit number {`sel_hi`,`sel_lo`}, with `sel_hi` as the upper bit. So 00 picks bit 0 and 11 picks bit 3.
- R3: With `rst` and `scan_en` low, a rising edge loads `y_prev` with the value `y_now` had just before that edge.
- R4: With `scan_en` high, a rising edge moves the table up one place: bit 0 takes `scan_in` and bit k takes bit k-1. `scan_out` always shows bit 3, so a bit shifted in appears on `scan_out` after exactly four shift edges.
- R5: With `scan_en` low, the table and `scan_out` keep their values across any number of functional edges.
- R6: With `scan_en` high and `rst` low, `y_now` and `y_prev` keep their values.
- R7: `rst` has no effect on the table. Bits shift during reset when `scan_en` is high, and the table contents are unchanged after a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the output registers, active high |
| scan_en | input | 1 | High: shift the truth table; low: evaluate the function |
| scan_in | input | 1 | Serial configuration data into table bit 0 |
| sel_lo | input | 1 | Lower select bit |
| sel_hi | input | 1 | Upper select bit |
| scan_out | output | 1 | Table bit 3, the serial configuration output |
| y_now | output | 1 | Registered function result |
| y_prev | output | 1 | The result from one functional edge earlier |

## Verification
Every result of this tile appears one edge after its stimulus. `y_now` reflects the select inputs presented before the edge. `y_prev` reflects `y_now` before that same edge. `scan_out` reflects the table after the shift. The bench drives inputs on the falling edge and pushes the predicted outputs into a queue. A monitor pops one item 1 ns after the following rising edge, so each comparison sees exactly one register stage of latency. A bit entering on `scan_in` is predicted at `scan_out` four shift edges later, and this places the chain depth under the same one-item-per-edge accounting.

// File: rtl/lut2_scan_tile.sv
module lut2_scan_tile (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic scan_in,
  input  logic sel_lo,
  input  logic sel_hi,
  output logic scan_out,
  output logic y_now,
  output logic y_prev
);
  localparam int DEPTH = 4;
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] tbl;
  logic [IW-1:0]    idx;

  assign idx      = {sel_hi, sel_lo};
  assign scan_out = tbl[DEPTH-1];

  always_ff @(posedge clk)
    if (scan_en) tbl <= {tbl[DEPTH-2:0], scan_in};

  always_ff @(posedge clk)
    if (rst) begin
      y_now  <= 1'b0;
      y_prev <= 1'b0;
    end else if (!scan_en) begin
      y_prev <= y_now;
      y_now  <= tbl[idx];
    end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!y_now && !y_prev));

  a_r3_history: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> (y_prev == $past(y_now)));

  a_r4_chain_step: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (scan_out == $past(tbl[DEPTH-2])));

  a_r5_table_kept: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> ($stable(tbl) && $stable(scan_out)));

  a_r6_outputs_frozen: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> ($stable(y_now) && $stable(y_prev)));
endmodule

// File: tb/sim_lut2_scan_tile.sv
module sim_lut2_scan_tile;
  logic clk = 1'b0;
  logic rst = 1'b1, scan_en = 1'b0, scan_in = 1'b0, sel_lo = 1'b0, sel_hi = 1'b0;
  logic scan_out, y_now, y_prev;

  always #2.5 clk = ~clk;

  lut2_scan_tile u0 (.clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .scan_out(scan_out), .y_now(y_now), .y_prev(y_prev));

  typedef struct {
    logic  yn;
    logic  yp;
    logic  so;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] mtbl = 4'b0;
  logic my_now = 1'b0, my_prev = 1'b0;

  task automatic push(input string tag);
    exp_t e;
    e.yn = my_now; e.yp = my_prev; e.so = mtbl[3]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic shift_bit(input logic b, input logic r, input string tag);
    @(negedge clk);
    rst = r; scan_en = 1'b1; scan_in = b;
    mtbl = {mtbl[2:0], b};
    if (r) begin my_now = 1'b0; my_prev = 1'b0; end
    push(tag);
  endtask

  task automatic load(input logic [3:0] t, input logic r, input string tag);
    for (int i = 3; i >= 0; i--) shift_bit(t[i], r, tag);
  endtask

  task automatic step(input logic hi, input logic lo, input logic r, input string tag);
    @(negedge clk);
    rst = r; scan_en = 1'b0; sel_hi = hi; sel_lo = lo;
    if (r) begin my_now = 1'b0; my_prev = 1'b0; end
    else begin my_prev = my_now; my_now = mtbl[{hi, lo}]; end
    push(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (y_now !== e.yn || y_prev !== e.yp || scan_out !== e.so) begin
        errors++;
        $display("FAIL %s: got y_now=%b y_prev=%b scan_out=%b, expected %b %b %b",
                 e.tag, y_now, y_prev, scan_out, e.yn, e.yp, e.so);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    load(4'b0110, 1'b1, "R4 R7 R1 shift during reset");
    step(1'b0, 1'b0, 1'b1, "R1 reset clears outputs");
    for (int k = 0; k < 4; k++) step(k[1], k[0], 1'b0, "R2 R3 R5 xor table");
    load(4'b1000, 1'b0, "R4 R6 and-table load");
    for (int k = 3; k >= 0; k--) step(k[1], k[0], 1'b0, "R2 R3 R5 and table");
    step(1'b1, 1'b1, 1'b0, "R2 R3 select 11");
    load(4'b1011, 1'b0, "R4 R6 outputs frozen");
    for (int k = 0; k < 12; k++) step(k[2], k[0], 1'b0, "R2 R3 R5 pattern");
    step(1'b1, 1'b1, 1'b1, "R1 reset mid-run");
    for (int k = 0; k < 4; k++) step(k[1], k[0], 1'b0, "R7 table kept after reset");
    load(4'b0001, 1'b0, "R4 R5 readback");
    for (int k = 0; k < 4; k++) step(k[0], k[1], 1'b0, "R2 R3 select order swap");
    @(negedge clk);
    scan_en = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule